// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Logic

This block produces the mailbox interrupts that two independent ports of a shared memory use to signal each other. Each port (called A and B here) presents a two-pin chip select (one pin active low, one active high), a read/write strobe, active-low byte-lane enables and an address. Each port has one active-low interrupt output. Both ports share one clock. The block watches the two topmost locations of the memory and treats accesses to them as mailbox traffic.

The highest location is the mailbox of port B, and the location just below it is the mailbox of port A. When port A writes the highest location, port B's interrupt goes low. Port B acknowledges the interrupt by reading that location, which returns its interrupt high. Traffic in the other direction works the same way through the second-highest location. The decoded address width can be 17, 18 or 19 bits. Address pins at or above that width are ignored. The memory array itself is not part of this block.

Top module: `mbx_irq_pair`

## Requirements
- R1: While `rst_n` is low, and from the first clock edge after it goes high until a mailbox write occurs, both `a_irq_n` and `b_irq_n` are 1.
- R2: An access counts only if, at the rising clock edge, `*_cs_n` is 0 and `*_cs` is 1. Any other combination leaves both interrupt outputs unchanged.
- R3: A write by port A (`a_wr_n` = 0) to the highest location drives `b_irq_n` to 0 from the clock edge that samples the write. In the decoded width the highest location has all bits set, which is 0x3FFFF for an 18-bit width.
- R4: A read by port B (`b_wr_n` = 1) of the highest location drives `b_irq_n` to 1 from the clock edge that samples the read.
- R5: A write by port B to the second-highest location drives `a_irq_n` to 0 from the sampling edge. In the decoded width this location has all bits set except bit 0, which is 0x3FFFE for an 18-bit width.
- R6: A read by port A of the second-highest location drives `a_irq_n` to 1 from the sampling edge.
- R7: A mailbox access counts only if at least one bit of the port's `*_lane_n` is 0. When all bits are 1, the access is ignored.
- R8: Only address bits below `ADDR_W` are decoded. `ADDR_W` must be 17, 18 or 19, and any address pins above it do not affect the outcome.
- R9: If the same clock edge samples both a set and a clear of the same interrupt, the interrupt ends up at 0 (set wins).
- R10: All other accesses leave both interrupts unchanged. This covers other addresses, a port writing the location it owns, and a port reading the location of the other port. Idle cycles also leave both interrupts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Asynchronous master reset, active low |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A strobe: 0 = write, 1 = read |
| a_lane_n | input | LANES | Port A byte-lane enables, active low |
| a_addr | input | PIN_W | Port A address pins |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B strobe: 0 = write, 1 = read |
| b_lane_n | input | LANES | Port B byte-lane enables, active low |
| b_addr | input | PIN_W | Port B address pins |
| a_irq_n | output | 1 | Interrupt to port A, active low |
| b_irq_n | output | 1 | Interrupt to port B, active low |

## Verification
The bench targets the corner cases around each mailbox access:

- **Select qualification.** It drives each select pin alone in its wrong state. A design that decoded only one of the two pins would raise an interrupt there.
- **Byte lanes.** It drives all byte lanes off. A design that ignored the lanes would set a flag it should not.
- **Upper address pin.** It drives the address pin above the decoded width during both a set and a clear. A design that compared the full pin width would miss both accesses.
- **Simultaneous set and clear.** It issues a set and a clear of the same flag on one edge. A design where the clear wins would leave the interrupt high.
- **Wrong-direction accesses.** It writes a port's own mailbox and reads the other port's mailbox. A design with the two mailbox locations swapped would then toggle the wrong interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

   // number of ports sharing the memory; index 0 is port A, 1 is port B
   localparam int NUM_PORTS = 2;

   // per-port decode result, indexed by mailbox owner (0 = A, 1 = B)
   typedef struct packed {
      logic [NUM_PORTS-1:0] wr;
      logic [NUM_PORTS-1:0] rd;
   } box_hit_t;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
   parameter int ADDR_W = 18,
   parameter int PIN_W  = 19,
   parameter int LANES  = 2
) (
   input  logic              cs_n,
   input  logic              cs,
   input  logic              wr_n,
   input  logic [LANES-1:0]  lane_n,
   input  logic [PIN_W-1:0]  addr,
   output mbx_pkg::box_hit_t hit
);
   import mbx_pkg::*;

   localparam int HI_W = ADDR_W - 1;

   logic [ADDR_W-1:0] eff_addr;
   logic              selected;
   logic              lane_ok;
   logic              in_window;
   acc_kind_e         kind;

   // strip address pins that the configured width does not use
   generate
      if (PIN_W > ADDR_W) begin : g_trim
         logic unused_hi;
         assign unused_hi = ^addr[PIN_W-1:ADDR_W];
         assign eff_addr  = addr[ADDR_W-1:0];
      end else begin : g_full
         assign eff_addr = addr;
      end
   endgenerate

   assign selected  = !cs_n && cs;
   assign lane_ok   = (lane_n != {LANES{1'b1}});
   assign in_window = (eff_addr[ADDR_W-1:1] == {HI_W{1'b1}});

   always_comb begin
      kind = ACC_IDLE;
      if (selected && lane_ok && in_window)
         kind = wr_n ? ACC_READ : ACC_WRITE;
   end

   // address bit 0 picks the mailbox owner: 1 -> port B, 0 -> port A
   always_comb begin
      hit = '0;
      hit.wr[eff_addr[0]] = (kind == ACC_WRITE);
      hit.rd[eff_addr[0]] = (kind == ACC_READ);
   end

endmodule

// File: rtl/mbx_flag_cell.sv
module mbx_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic irq_n
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (set_req)
         pend_q <= 1'b1;
      else if (clr_req)
         pend_q <= 1'b0;
   end

   assign irq_n = ~pend_q;

endmodule

// File: rtl/mbx_irq_pair.sv
module mbx_irq_pair #(
   parameter int ADDR_W = 18,
   parameter int PIN_W  = 19,
   parameter int LANES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_cs_n,
   input  logic             a_cs,
   input  logic             a_wr_n,
   input  logic [LANES-1:0] a_lane_n,
   input  logic [PIN_W-1:0] a_addr,
   input  logic             b_cs_n,
   input  logic             b_cs,
   input  logic             b_wr_n,
   input  logic [LANES-1:0] b_lane_n,
   input  logic [PIN_W-1:0] b_addr,
   output logic             a_irq_n,
   output logic             b_irq_n
);
   import mbx_pkg::*;

   localparam int NP = NUM_PORTS;

   // elaboration-time parameter checks (R8)
   generate
      if (ADDR_W < 17 || ADDR_W > 19) begin : g_bad_aw
         $error("mbx_irq_pair: ADDR_W must be 17, 18 or 19");
      end
      if (PIN_W < ADDR_W) begin : g_bad_pw
         $error("mbx_irq_pair: PIN_W must be at least ADDR_W");
      end
      if (LANES < 1) begin : g_bad_ln
         $error("mbx_irq_pair: LANES must be positive");
      end
   endgenerate

   logic [NP-1:0]            cs_n_v;
   logic [NP-1:0]            cs_v;
   logic [NP-1:0]            wr_n_v;
   logic [NP-1:0][LANES-1:0] lane_v;
   logic [NP-1:0][PIN_W-1:0] addr_v;
   box_hit_t                 hit_v [NP];
   logic [NP-1:0]            irq_v;

   assign cs_n_v = {b_cs_n, a_cs_n};
   assign cs_v   = {b_cs,   a_cs};
   assign wr_n_v = {b_wr_n, a_wr_n};
   assign lane_v = {b_lane_n, a_lane_n};
   assign addr_v = {b_addr, a_addr};

   generate
      for (genvar p = 0; p < NP; p++) begin : g_port
         mbx_port_decode #(
            .ADDR_W (ADDR_W),
            .PIN_W  (PIN_W),
            .LANES  (LANES)
         ) u_dec (
            .cs_n   (cs_n_v[p]),
            .cs     (cs_v[p]),
            .wr_n   (wr_n_v[p]),
            .lane_n (lane_v[p]),
            .addr   (addr_v[p]),
            .hit    (hit_v[p])
         );

         // port p's flag: set by the peer writing p's box, cleared by p reading it
         mbx_flag_cell u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (hit_v[NP-1-p].wr[p]),
            .clr_req (hit_v[p].rd[p]),
            .irq_n   (irq_v[p])
         );
      end
   endgenerate

   assign a_irq_n = irq_v[0];
   assign b_irq_n = irq_v[1];

endmodule

// File: rtl/mbx_irq_pair_chk.sv
module mbx_irq_pair_chk #(
   parameter int ADDR_W = 18,
   parameter int PIN_W  = 19,
   parameter int LANES  = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             a_cs_n,
   input logic             a_cs,
   input logic             a_wr_n,
   input logic [LANES-1:0] a_lane_n,
   input logic [PIN_W-1:0] a_addr,
   input logic             b_cs_n,
   input logic             b_cs,
   input logic             b_wr_n,
   input logic [LANES-1:0] b_lane_n,
   input logic [PIN_W-1:0] b_addr,
   input logic             a_irq_n,
   input logic             b_irq_n
);
   localparam logic [ADDR_W-1:0] BOX_B = {ADDR_W{1'b1}};
   localparam logic [ADDR_W-1:0] BOX_A = {{(ADDR_W-1){1'b1}}, 1'b0};

   logic a_go, b_go, set_b, clr_b, set_a, clr_a;

   assign a_go  = (a_cs_n == 1'b0) && (a_cs == 1'b1) && (|(~a_lane_n));
   assign b_go  = (b_cs_n == 1'b0) && (b_cs == 1'b1) && (|(~b_lane_n));
   assign set_b = a_go && !a_wr_n && (a_addr[ADDR_W-1:0] == BOX_B);
   assign clr_b = b_go &&  b_wr_n && (b_addr[ADDR_W-1:0] == BOX_B);
   assign set_a = b_go && !b_wr_n && (b_addr[ADDR_W-1:0] == BOX_A);
   assign clr_a = a_go &&  a_wr_n && (a_addr[ADDR_W-1:0] == BOX_A);

   a_r1_reset_high: assert property (@(posedge clk)
      !rst_n |=> (a_irq_n && b_irq_n));

   a_r3_b_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_b |=> !b_irq_n);

   a_r4_b_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_b && !set_b) |=> b_irq_n);

   a_r5_a_set: assert property (@(posedge clk) disable iff (!rst_n)
      set_a |=> !a_irq_n);

   a_r6_a_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_a && !set_a) |=> a_irq_n);

   a_r10_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_b && !clr_b) |=> $stable(b_irq_n));

   a_r10_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_a && !clr_a) |=> $stable(a_irq_n));

endmodule

bind mbx_irq_pair mbx_irq_pair_chk #(
   .ADDR_W (ADDR_W),
   .PIN_W  (PIN_W),
   .LANES  (LANES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .a_cs_n   (a_cs_n),
   .a_cs     (a_cs),
   .a_wr_n   (a_wr_n),
   .a_lane_n (a_lane_n),
   .a_addr   (a_addr),
   .b_cs_n   (b_cs_n),
   .b_cs     (b_cs),
   .b_wr_n   (b_wr_n),
   .b_lane_n (b_lane_n),
   .b_addr   (b_addr),
   .a_irq_n  (a_irq_n),
   .b_irq_n  (b_irq_n)
);

// File: tb/mbx_irq_pair_tb_top.sv
module mbx_irq_pair_tb_top;
   localparam int CLK_NS = 10;
   localparam int AW = 18;
   localparam int PW = 19;
   localparam int LN = 2;
   localparam logic [PW-1:0] BOXB = 19'h3FFFF;
   localparam logic [PW-1:0] BOXA = 19'h3FFFE;
   localparam logic [PW-1:0] HIBIT = 19'h40000;
   localparam logic [LN-1:0] ON = 2'b10;
   localparam logic [LN-1:0] OFF = 2'b11;

   logic clk = 1'b0;
   logic rst_n;
   logic a_cs_n, a_cs, a_wr_n, b_cs_n, b_cs, b_wr_n;
   logic [LN-1:0] a_lane_n, b_lane_n;
   logic [PW-1:0] a_addr, b_addr;
   logic a_irq_n, b_irq_n;

   always #(CLK_NS/2) clk = ~clk;

   mbx_irq_pair #(.ADDR_W(AW), .PIN_W(PW), .LANES(LN)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_cs_n(a_cs_n), .a_cs(a_cs), .a_wr_n(a_wr_n), .a_lane_n(a_lane_n), .a_addr(a_addr),
      .b_cs_n(b_cs_n), .b_cs(b_cs), .b_wr_n(b_wr_n), .b_lane_n(b_lane_n), .b_addr(b_addr),
      .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [1:0] q_exp[$];
   string q_tag[$];
   logic pend_a = 1'b0;
   logic pend_b = 1'b0;

   task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {a_irq_n,b_irq_n} actual %b expected %b", tag, act, exp);
      end
   endtask

   // driver: one clock of stimulus on both ports, expected result pushed
   task automatic cyc(
      input logic acsn, input logic acs, input logic awn, input logic [LN-1:0] al, input logic [PW-1:0] aa,
      input logic bcsn, input logic bcs, input logic bwn, input logic [LN-1:0] bl, input logic [PW-1:0] ba,
      input string tag);
      logic ag, bg, sa, ca, sb, cb;
      @(negedge clk);
      a_cs_n = acsn; a_cs = acs; a_wr_n = awn; a_lane_n = al; a_addr = aa;
      b_cs_n = bcsn; b_cs = bcs; b_wr_n = bwn; b_lane_n = bl; b_addr = ba;
      ag = !acsn && acs && (al != OFF);
      bg = !bcsn && bcs && (bl != OFF);
      sb = ag && !awn && (aa[AW-1:0] == 18'h3FFFF);
      cb = bg &&  bwn && (ba[AW-1:0] == 18'h3FFFF);
      sa = bg && !bwn && (ba[AW-1:0] == 18'h3FFFE);
      ca = ag &&  awn && (aa[AW-1:0] == 18'h3FFFE);
      if (sa) pend_a = 1'b1; else if (ca) pend_a = 1'b0;
      if (sb) pend_b = 1'b1; else if (cb) pend_b = 1'b0;
      q_exp.push_back({~pend_a, ~pend_b});
      q_tag.push_back(tag);
   endtask

   // monitor: sample a quarter period after each edge, compare with queue
   initial begin
      wait (rst_n === 1'b1);
      forever begin
         @(posedge clk);
         #(CLK_NS/4);
         if (q_exp.size() > 0) begin
            logic [1:0] e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            check(t, {a_irq_n, b_irq_n}, e);
         end
      end
   end

   task automatic summary();
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      a_cs_n = 1'b1; a_cs = 1'b0; a_wr_n = 1'b1; a_lane_n = OFF; a_addr = '0;
      b_cs_n = 1'b1; b_cs = 1'b0; b_wr_n = 1'b1; b_lane_n = OFF; b_addr = '0;
      repeat (2) @(negedge clk);
      check("R1 in reset", {a_irq_n, b_irq_n}, 2'b11);
      // a mailbox write during reset must not count (R1)
      a_cs_n = 1'b0; a_cs = 1'b1; a_wr_n = 1'b0; a_lane_n = ON; a_addr = BOXB;
      @(negedge clk);
      check("R1 write in reset", {a_irq_n, b_irq_n}, 2'b11);
      a_cs_n = 1'b1; a_cs = 1'b0; a_wr_n = 1'b1;
      rst_n = 1'b1;

      cyc(1,0,1,OFF,'0,   1,0,1,OFF,'0,   "R1/R10 idle after reset");
      cyc(0,1,0,ON,BOXB,  1,0,1,OFF,'0,   "R3 A writes B box");
      cyc(1,0,1,OFF,'0,   1,0,1,OFF,'0,   "R10 hold low");
      cyc(1,0,1,OFF,'0,   0,1,1,ON,BOXB,  "R4 B reads its box");
      cyc(1,1,0,ON,BOXB,  1,0,1,OFF,'0,   "R2 cs_n high ignored");
      cyc(0,0,0,ON,BOXB,  1,0,1,OFF,'0,   "R2 cs low ignored");
      cyc(0,1,0,OFF,BOXB, 1,0,1,OFF,'0,   "R7 all lanes off ignored");
      cyc(0,1,0,2'b01,BOXB|HIBIT, 1,0,1,OFF,'0, "R8 upper pin ignored on set");
      cyc(1,0,1,OFF,'0,   0,1,1,2'b00,BOXB|HIBIT, "R8 upper pin ignored on clear");
      cyc(0,1,0,ON,19'h3FFFD, 1,0,1,OFF,'0, "R10 other address");
      cyc(0,1,0,ON,BOXA,  1,0,1,OFF,'0,   "R10 A writes own box");
      cyc(1,0,1,OFF,'0,   0,1,0,ON,BOXA,  "R5 B writes A box");
      cyc(0,1,1,ON,BOXB,  1,0,1,OFF,'0,   "R10 A reads B box");
      cyc(0,1,1,OFF,BOXA, 1,0,1,OFF,'0,   "R7 read with lanes off ignored");
      cyc(0,1,1,2'b01,BOXA, 1,0,1,OFF,'0, "R6 A reads its box");
      cyc(0,1,0,ON,BOXB,  1,0,1,OFF,'0,   "R3 set B again");
      cyc(0,1,0,ON,BOXB,  0,1,1,ON,BOXB,  "R9 set wins over clear on B");
      cyc(1,0,1,OFF,'0,   0,1,1,ON,BOXB,  "R4 clear B after collision");
      cyc(0,1,1,ON,BOXA,  0,1,0,ON,BOXA,  "R9 set wins over clear on A");
      cyc(0,1,0,ON,BOXB,  1,0,1,OFF,'0,   "R3 both flags pending");
      cyc(1,0,1,OFF,'0,   0,1,0,ON,BOXB,  "R10 B writes own box");
      cyc(0,1,1,ON,BOXA,  0,1,1,ON,BOXB,  "R4/R6 both cleared together");
      cyc(1,0,1,OFF,'0,   1,0,1,OFF,'0,   "R10 final idle");

      repeat (3) @(posedge clk);
      #(CLK_NS/2);
      if (q_exp.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL scoreboard: actual %0d items left expected 0", q_exp.size());
      end
      summary();
      $finish;
   end
endmodule